// File: doc/BRIEF.md
# Up/Down Modulo Timer Counter

This block is a 16-bit timer counter that takes one step for each clock cycle in which its count-enable input is high. It has three ways of counting. In free-running mode it covers the whole 16-bit range. In modulo mode it counts up to a programmable limit and returns to zero. In center-aligned mode it counts up to the limit, turns around and counts back down to zero. That up/down ramp is the time base for symmetric PWM: zero is the middle of a period and the top turn is the end of it.

A sticky overflow flag marks the end of each counting period. In the edge-aligned modes that is the wrap to zero. In center-aligned mode it is the turn at the top. Software clears the flag with a one-cycle strobe. An interrupt enable decides whether the flag also drives a level interrupt output or is only polled. The count, the present counting direction, the flag and the interrupt are all outputs. Channel compare/capture and any register bus sit outside this block.

Top module: `updown_mod_timer`

## Requirements
- R1: A synchronous active-high reset sets the count to 0x0000, the direction to up (dir_down = 0) and clears the flag.
- R2: In a cycle where cnt_en is low, the count and the direction keep their values.
- R3: In edge-aligned mode (center_mode = 0) with modulus = 0, the count steps from 0x0000 up to 0xFFFF, then wraps to 0x0000. The flag sets on the 0xFFFF-to-0x0000 step and on no other step.
- R4: In edge-aligned mode with a nonzero modulus, the count steps up to the modulus and then wraps to 0x0000. The flag sets on that wrap. A count already above the modulus also wraps to 0x0000 on its next step.
- R5: In center-aligned mode (center_mode = 1) with a nonzero modulus, the count rises to the modulus. The next step goes to modulus - 1, sets dir_down = 1 and sets the flag.
- R6: In center-aligned mode, a count that is falling and has reached 0x0000 steps to 0x0001 and sets dir_down = 0. The flag does not set on this bottom turn.
- R7: In center-aligned mode with modulus = 0, the count stays at 0x0000 with dir_down = 0, and the flag does not set.
- R8: Once set, the flag stays set until a cycle with flag_clr high. If a set condition and flag_clr fall in the same cycle, the flag ends up set.
- R9: irq is high exactly while the flag is set and irq_en is 1. With irq_en = 0, irq stays low whatever the flag does.
- R10: In edge-aligned mode every step leaves dir_down = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count enable; the counter steps once per cycle while high |
| modulus | input | 16 | Count limit; 0 selects the full range in edge-aligned mode |
| center_mode | input | 1 | 1 = center-aligned up/down counting, 0 = edge-aligned |
| irq_en | input | 1 | Interrupt enable for the overflow flag |
| flag_clr | input | 1 | One-cycle strobe that clears the overflow flag |
| count | output | 16 | Present counter value |
| dir_down | output | 1 | 1 while the counter is counting down |
| ovf_flag | output | 1 | Sticky end-of-period flag |
| irq | output | 1 | Level interrupt: flag AND enable |

## Verification
The bench builds the counter with its default width of 16 bits. At that width a full free-running lap of 65,536 steps fits easily in the run, so the real 0xFFFF-to-0x0000 wrap is observed directly rather than in a narrowed copy. Modulus values of 0, 1 and 5 cover the degenerate center-aligned hold, the tightest possible up/down ramp (0,1,0,1...) with a flag every second step, and a longer ramp in which the top and bottom turns can be told apart by count, direction and flag.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Direction of the most recent step
    typedef enum logic {
        CNT_UP   = 1'b0,
        CNT_DOWN = 1'b1
    } cnt_dir_e;

    // Counting mode resolved from the mode bit and the modulus
    typedef enum logic [1:0] {
        MODE_FREE        = 2'd0,
        MODE_MODULO      = 2'd1,
        MODE_CENTER      = 2'd2,
        MODE_CENTER_IDLE = 2'd3
    } run_mode_e;

    // Events produced by one step of the counter
    typedef struct packed {
        logic wrap;     // edge-aligned return to zero
        logic top_rev;  // center-aligned turn at the limit
    } step_evt_t;

    function automatic run_mode_e pick_mode(input logic center, input logic mod_zero);
        if (center)
            return mod_zero ? MODE_CENTER_IDLE : MODE_CENTER;
        else
            return mod_zero ? MODE_FREE : MODE_MODULO;
    endfunction

    function automatic logic period_end(input step_evt_t e);
        return e.wrap | e.top_rev;
    endfunction

endpackage

// File: rtl/tmr_mode_decode.sv
module tmr_mode_decode
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             center_mode,
    input  logic [CNT_W-1:0] modulus,
    output run_mode_e        mode,
    output logic [CNT_W-1:0] limit
);
    localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

    logic mod_zero;

    always_comb begin
        mod_zero = (modulus == '0);
        mode     = pick_mode(center_mode, mod_zero);
        limit    = (mode == MODE_FREE) ? FULL : modulus;
    end

endmodule

// File: rtl/tmr_step.sv
module tmr_step
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] count,
    input  cnt_dir_e         dir,
    input  run_mode_e        mode,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] next_count,
    output cnt_dir_e         next_dir,
    output step_evt_t        evt
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic at_top;
    logic at_bottom;

    always_comb begin
        at_top     = (count >= limit);
        at_bottom  = (count == '0);
        next_count = count;
        next_dir   = dir;
        evt        = '0;
        unique case (mode)
            MODE_FREE, MODE_MODULO: begin
                next_dir = CNT_UP;
                if (at_top) begin
                    next_count = '0;
                    evt.wrap   = 1'b1;
                end else begin
                    next_count = count + ONE;
                end
            end
            MODE_CENTER: begin
                if (dir == CNT_UP) begin
                    if (at_top) begin
                        next_count  = count - ONE;
                        next_dir    = CNT_DOWN;
                        evt.top_rev = 1'b1;
                    end else begin
                        next_count = count + ONE;
                    end
                end else begin
                    if (at_bottom) begin
                        next_count = ONE;
                        next_dir   = CNT_UP;
                    end else begin
                        next_count = count - ONE;
                    end
                end
            end
            MODE_CENTER_IDLE: begin
                next_count = '0;
                next_dir   = CNT_UP;
            end
            default: begin
                next_count = count;
                next_dir   = dir;
            end
        endcase
    end

    // R5/R6: a center-aligned step never raises both events
    always_comb begin
        a_r5_single_event: assert (!(evt.wrap && evt.top_rev))
            else $error("a_r5_single_event: wrap and top turn together");
    end

endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clr_req,
    input  logic irq_en,
    output logic flag,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (set_req)
            flag <= 1'b1;
        else if (clr_req)
            flag <= 1'b0;
    end

    assign irq = flag & irq_en;

    // R8: sticky until cleared
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr_req) |=> flag)
        else $error("a_r8_sticky: flag dropped without clear");

    // R8: set wins over a clear in the same cycle
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        set_req |=> flag)
        else $error("a_r8_set_wins: flag not set after set request");

    // R9: enable gates the interrupt output
    a_r9_gated: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq)
        else $error("a_r9_gated: irq high with enable off");

endmodule

// File: rtl/updown_mod_timer.sv
module updown_mod_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic [CNT_W-1:0] modulus,
    input  logic             center_mode,
    input  logic             irq_en,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count,
    output logic             dir_down,
    output logic             ovf_flag,
    output logic             irq
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    run_mode_e        mode;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] next_count;
    cnt_dir_e         dir_q;
    cnt_dir_e         next_dir;
    step_evt_t        evt;
    logic             flag_set;

    tmr_mode_decode #(.CNT_W(CNT_W)) u_decode (
        .center_mode (center_mode),
        .modulus     (modulus),
        .mode        (mode),
        .limit       (limit)
    );

    tmr_step #(.CNT_W(CNT_W)) u_step (
        .count      (count),
        .dir        (dir_q),
        .mode       (mode),
        .limit      (limit),
        .next_count (next_count),
        .next_dir   (next_dir),
        .evt        (evt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            dir_q <= CNT_UP;
        end else if (cnt_en) begin
            count <= next_count;
            dir_q <= next_dir;
        end
    end

    assign dir_down = (dir_q == CNT_DOWN);
    assign flag_set = cnt_en & period_end(evt);

    tmr_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .set_req (flag_set),
        .clr_req (flag_clr),
        .irq_en  (irq_en),
        .flag    (ovf_flag),
        .irq     (irq)
    );

    // R1: reset state
    a_r1_reset: assert property (@(posedge clk)
        rst |=> (count == '0 && !dir_down && !ovf_flag))
        else $error("a_r1_reset: bad state after reset");

    // R2: hold while not enabled
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> ($stable(count) && $stable(dir_down)))
        else $error("a_r2_hold: counter moved while disabled");

    // R4: wrap at the modulus in edge-aligned mode
    a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !center_mode && modulus != '0 && count == modulus)
        |=> (count == '0 && ovf_flag))
        else $error("a_r4_wrap: no wrap at modulus");

    // R5: top turn in center-aligned mode
    a_r5_top_turn: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && center_mode && !dir_down && modulus != '0 && count == modulus)
        |=> (count == $past(modulus) - ONE && dir_down && ovf_flag))
        else $error("a_r5_top_turn: bad top reversal");

    // R6: bottom turn never sets the flag
    a_r6_bottom_quiet: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && center_mode && dir_down && count == '0 && !ovf_flag)
        |=> (!ovf_flag && !dir_down && count == ONE))
        else $error("a_r6_bottom_quiet: bad bottom reversal");

    // R10: edge-aligned steps count up
    a_r10_edge_up: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !center_mode) |=> !dir_down)
        else $error("a_r10_edge_up: down direction in edge mode");

endmodule

// File: tb/updown_mod_timer_bench.sv
module updown_mod_timer_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        cnt_en;
    logic [15:0] modulus;
    logic        center_mode;
    logic        irq_en;
    logic        flag_clr;
    logic [15:0] count;
    logic        dir_down;
    logic        ovf_flag;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    updown_mod_timer #(.CNT_W(16)) u_updown_mod_timer (
        .clk         (clk),
        .rst         (rst),
        .cnt_en      (cnt_en),
        .modulus     (modulus),
        .center_mode (center_mode),
        .irq_en      (irq_en),
        .flag_clr    (flag_clr),
        .count       (count),
        .dir_down    (dir_down),
        .ovf_flag    (ovf_flag),
        .irq         (irq)
    );

    // {center, modulus, ticks, exp_count, exp_dir_down, exp_flag}
    localparam int NV = 12;
    localparam logic [50:0] VECS [0:NV-1] = '{
        {1'b0, 16'd5, 16'd3,  16'd3, 1'b0, 1'b0},
        {1'b0, 16'd5, 16'd5,  16'd5, 1'b0, 1'b0},
        {1'b0, 16'd5, 16'd6,  16'd0, 1'b0, 1'b1},
        {1'b0, 16'd1, 16'd2,  16'd0, 1'b0, 1'b1},
        {1'b1, 16'd5, 16'd5,  16'd5, 1'b0, 1'b0},
        {1'b1, 16'd5, 16'd6,  16'd4, 1'b1, 1'b1},
        {1'b1, 16'd5, 16'd10, 16'd0, 1'b1, 1'b1},
        {1'b1, 16'd5, 16'd11, 16'd1, 1'b0, 1'b1},
        {1'b1, 16'd1, 16'd1,  16'd1, 1'b0, 1'b0},
        {1'b1, 16'd1, 16'd2,  16'd0, 1'b1, 1'b1},
        {1'b1, 16'd1, 16'd3,  16'd1, 1'b0, 1'b1},
        {1'b1, 16'd0, 16'd3,  16'd0, 1'b0, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic do_reset();
        rst = 1'b1; cnt_en = 1'b0; flag_clr = 1'b0;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run(input int n);
        cnt_en = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        cnt_en = 1'b0;
    endtask

    task automatic pulse_clr();
        flag_clr = 1'b1;
        @(posedge clk); @(negedge clk);
        flag_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cnt_en = 1'b0; modulus = '0; center_mode = 1'b0;
        irq_en = 1'b0; flag_clr = 1'b0;
        @(negedge clk);
        do_reset();
        check("R1 count", 32'(count), 0);
        check("R1 dir", 32'(dir_down), 0);
        check("R1 flag", 32'(ovf_flag), 0);

        // vector table: R4 edge modulo, R5/R6 center ramps, R7 idle
        for (int i = 0; i < NV; i++) begin
            do_reset();
            center_mode = VECS[i][50];
            modulus     = VECS[i][49:34];
            run(int'(VECS[i][33:18]));
            if (!VECS[i][50])            check($sformatf("R4 v%0d count", i), 32'(count), 32'(VECS[i][17:2]));
            else if (VECS[i][49:34] == 0) check($sformatf("R7 v%0d count", i), 32'(count), 32'(VECS[i][17:2]));
            else                          check($sformatf("R5/R6 v%0d count", i), 32'(count), 32'(VECS[i][17:2]));
            check($sformatf("R10/R6 v%0d dir", i), 32'(dir_down), 32'(VECS[i][1]));
            check($sformatf("R5 v%0d flag", i), 32'(ovf_flag), 32'(VECS[i][0]));
        end

        // R3: full-range free running wrap
        do_reset();
        center_mode = 1'b0; modulus = '0;
        run(65535);
        check("R3 count at top", 32'(count), 32'hFFFF);
        check("R3 no flag before wrap", 32'(ovf_flag), 0);
        run(1);
        check("R3 count after wrap", 32'(count), 0);
        check("R3 flag after wrap", 32'(ovf_flag), 1);

        // R6: bottom turn leaves a cleared flag clear
        do_reset();
        center_mode = 1'b1; modulus = 16'd5;
        run(6);
        pulse_clr();
        check("R8 clear", 32'(ovf_flag), 0);
        run(4);
        check("R6 at bottom", 32'(count), 0);
        run(1);
        check("R6 after bottom count", 32'(count), 1);
        check("R6 after bottom dir", 32'(dir_down), 0);
        check("R6 no flag at bottom", 32'(ovf_flag), 0);

        // R2: hold while disabled
        repeat (5) @(negedge clk);
        check("R2 hold count", 32'(count), 1);
        check("R2 hold dir", 32'(dir_down), 0);

        // R4: count above a lowered modulus wraps on next step
        do_reset();
        center_mode = 1'b0; modulus = 16'd9;
        run(7);
        modulus = 16'd3;
        run(1);
        check("R4 above modulus", 32'(count), 0);
        check("R4 above modulus flag", 32'(ovf_flag), 1);

        // R8: set and clear in the same cycle
        do_reset();
        center_mode = 1'b0; modulus = 16'd1;
        run(1);
        flag_clr = 1'b1; cnt_en = 1'b1;
        @(posedge clk); @(negedge clk);
        flag_clr = 1'b0; cnt_en = 1'b0;
        check("R8 set wins", 32'(ovf_flag), 1);
        repeat (3) @(negedge clk);
        check("R8 sticky", 32'(ovf_flag), 1);

        // R9: interrupt gating
        irq_en = 1'b0;
        @(negedge clk);
        check("R9 irq off", 32'(irq), 0);
        irq_en = 1'b1;
        #1;
        check("R9 irq on", 32'(irq), 1);
        pulse_clr();
        check("R9 irq after clear", 32'(irq), 0);

        // R1: reset from a busy state
        center_mode = 1'b1; modulus = 16'd4;
        run(6);
        do_reset();
        check("R1 count after busy", 32'(count), 0);
        check("R1 dir after busy", 32'(dir_down), 0);
        check("R1 flag after busy", 32'(ovf_flag), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule